// File: doc/BRIEF.md
# I2C Register Target with Per-Byte CRC-8

This block is an I2C target that gives a bus controller byte access to a generic register port. The first byte after START carries the 7-bit target address, which comes from the `dev_addr` input, and the direction bit. With address 0x08, a write frame begins with 0x10 and a read frame begins with 0x11. In a write, the next byte sets a register pointer. Each data byte that follows is committed to the pointer, and the pointer then advances. A read returns the byte at the pointer and then advances it. The controller can turn the bus around with a Repeated Start, or it can end the pointer-setting write with STOP and open a fresh read frame.

When `crc_en` is high, a CRC-8 byte follows each data byte in both directions. The CRC uses polynomial 0x07, starts from zero and works MSB first. What the CRC covers depends on where the byte sits in the transaction. A write CRC that does not match is refused. A CRC byte that the controller refuses ends the read. SCL and SDA arrive already synchronised to `clk`. The block pulls SDA low only through `sda_oe`.

Top module: `i2c_crc_target`

## Requirements
- R1: While reset is asserted and after it is released, `sda_oe`, `reg_we` and `reg_re` are low.
- R2: The target ACKs an address byte only when bits 7:1 equal `dev_addr` (bit 0: 0 = write, 1 = read). On a mismatch it NACKs and ignores every byte until the next START.
- R3: In a write, the byte after the address is the register pointer. With `crc_en` low, each later byte is ACKed and committed as a one-cycle `reg_we` pulse at the current pointer.
- R4: The pointer advances by one after every data byte, in writes and in reads, and wraps from 0xFF to 0x00.
- R5: A read that follows a Repeated Start returns the byte at the pointer. The target keeps sending further bytes while the controller ACKs them and stops after a NACK. Each fetch is a one-cycle `reg_re` pulse.
- R6: A pointer set by a write frame that ends with STOP is kept, so a later separate read frame starts there.
- R7: With `crc_en` high, a CRC byte follows each write data byte. The first one covers the write address byte, the pointer byte and the data byte. Each later one covers its data byte alone. A data byte is committed only after its matching CRC has been ACKed.
- R8: A write CRC that does not match is NACKed. The pending byte is discarded and the target goes idle, so every following byte is NACKed until the next START.
- R9: With `crc_en` high, a CRC byte follows each read data byte. After a Repeated Start, the first CRC covers the write address byte, the pointer byte, the read address byte and the data byte. The CRC clears after each CRC byte and at STOP, so a read frame without a Repeated Start covers only the read address byte and the data byte. Later bytes cover the data byte alone.
- R10: If the controller NACKs a read CRC byte, the target goes idle, leaves SDA released and fetches no further register.
- R11: A START or STOP inside a byte abandons that byte. The next frame is decoded correctly, and `sda_oe` is low in the cycle after a STOP.
- R12: `sda_oe` changes only in a cycle whose SCL sample was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| crc_en | input | 1 | Enables the CRC byte after each data byte |
| dev_addr | input | 7 | Target address |
| reg_we | output | 1 | One-cycle write strobe |
| reg_waddr | output | AW | Write register address |
| reg_wdata | output | 8 | Write data |
| reg_re | output | 1 | One-cycle read fetch strobe |
| reg_raddr | output | AW | Read register address (the current pointer) |
| reg_rdata | input | 8 | Read data for `reg_raddr`, same cycle |

## Verification
The bench builds the block with the default `AW = 8`, so the register space is 256 entries. A directed block starting at 0xFE therefore checks pointer wrap together with CRC coverage. The address starts at 0x08, which gives the 0x10/0x11 framing, and later moves to 0x2A to exercise the configurable match. Random frames mix `crc_en`, direction, length, Repeated Start versus separate frames, and injected CRC faults.

// File: rtl/i2c_crc_target.sv
module i2c_crc_target #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          crc_en,
  input  logic [6:0]    dev_addr,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic          reg_re,
  output logic [AW-1:0] reg_raddr,
  input  logic [7:0]    reg_rdata
);
  localparam logic [7:0] POLY = 8'h07;
  localparam logic [3:0] BITS = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_WDAT, S_WCRC, S_RDAT, S_RCRC} st_t;

  st_t st;
  logic scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh, tx, crc, wbuf;
  logic ack_ok, rw, keep, mack;
  logic [AW-1:0] ptr;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  logic scl_rise, scl_fall, start_c, stop_c, hit, crc_ok;
  logic [7:0] rx_crc, rd_crc;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_c   = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c    = scl_i & scl_q & ~sda_q & sda_i;
  assign hit       = (sh[7:1] == dev_addr);
  assign crc_ok    = (sh == crc);
  assign rx_crc    = crc8(crc, sh);
  assign rd_crc    = crc8(crc, reg_rdata);
  assign reg_raddr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      crc       <= '0;
      wbuf      <= '0;
      ack_ok    <= 1'b0;
      rw        <= 1'b0;
      keep      <= 1'b0;
      mack      <= 1'b1;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
      reg_re    <= 1'b0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (stop_c) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        crc    <= '0;
        keep   <= 1'b0;
      end else if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        keep   <= 1'b0;
        if (!keep) crc <= '0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < BITS) sh <= {sh[6:0], sda_i};
          if (cnt == BITS) mack <= sda_i;
          cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == BITS) begin
            case (st)
              S_ADDR: begin
                ack_ok <= hit;
                sda_oe <= hit;
                rw     <= sh[0];
                crc    <= rx_crc;
              end
              S_REG: begin
                ack_ok <= 1'b1;
                sda_oe <= 1'b1;
                ptr    <= AW'(sh);
                crc    <= rx_crc;
                keep   <= 1'b1;
              end
              S_WDAT: begin
                ack_ok <= 1'b1;
                sda_oe <= 1'b1;
                keep   <= 1'b0;
                wbuf   <= sh;
                if (crc_en) begin
                  crc <= rx_crc;
                end else begin
                  crc       <= '0;
                  reg_we    <= 1'b1;
                  reg_waddr <= ptr;
                  reg_wdata <= sh;
                  ptr       <= ptr + AW'(1);
                end
              end
              S_WCRC: begin
                ack_ok <= crc_ok;
                sda_oe <= crc_ok;
                crc    <= '0;
                if (crc_ok) begin
                  reg_we    <= 1'b1;
                  reg_waddr <= ptr;
                  reg_wdata <= wbuf;
                  ptr       <= ptr + AW'(1);
                end
              end
              S_RDAT: begin
                sda_oe <= 1'b0;
                ptr    <= ptr + AW'(1);
                if (!crc_en) crc <= '0;
              end
              S_RCRC: begin
                sda_oe <= 1'b0;
                crc    <= '0;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt > BITS) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ADDR: begin
                if (!ack_ok) begin
                  st <= S_IDLE;
                end else if (rw) begin
                  st     <= S_RDAT;
                  tx     <= reg_rdata;
                  sda_oe <= ~reg_rdata[7];
                  crc    <= rd_crc;
                  reg_re <= 1'b1;
                end else begin
                  st <= S_REG;
                end
              end
              S_REG:  st <= S_WDAT;
              S_WDAT: st <= crc_en ? S_WCRC : S_WDAT;
              S_WCRC: st <= ack_ok ? S_WDAT : S_IDLE;
              S_RDAT: begin
                if (mack) begin
                  st <= S_IDLE;
                end else if (crc_en) begin
                  st     <= S_RCRC;
                  tx     <= crc;
                  sda_oe <= ~crc[7];
                end else begin
                  tx     <= reg_rdata;
                  sda_oe <= ~reg_rdata[7];
                  crc    <= rd_crc;
                  reg_re <= 1'b1;
                end
              end
              S_RCRC: begin
                if (mack) begin
                  st <= S_IDLE;
                end else begin
                  st     <= S_RDAT;
                  tx     <= reg_rdata;
                  sda_oe <= ~reg_rdata[7];
                  crc    <= rd_crc;
                  reg_re <= 1'b1;
                end
              end
              default: st <= S_IDLE;
            endcase
          end else if (cnt != 4'd0 && (st == S_RDAT || st == S_RCRC)) begin
            sda_oe <= ~tx[6];
            tx     <= tx << 1;
          end
        end
      end
    end
  end
endmodule

module i2c_crc_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);
  logic cq, dq, stop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq <= 1'b1;
      dq <= 1'b1;
    end else begin
      cq <= scl_i;
      dq <= sda_i;
    end
  end

  assign stop_seen = scl_i & cq & ~dq & sda_i;

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);

  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_re_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  p_sda_low_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind i2c_crc_target i2c_crc_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/sim_i2c_crc_target.sv
module sim_i2c_crc_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda, sda_oe;
  logic crc_en = 1'b0;
  logic [6:0] dev_addr = 7'h08;
  logic reg_we, reg_re;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;

  assign sda = ~(m_low | sda_oe);

  i2c_crc_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .crc_en(crc_en), .dev_addr(dev_addr), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] dbuf [8];
  int n_we, n_re, checks, errors, viol;
  logic prev_oe, prev_scl;

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 5);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      n_we <= 0;
      n_re <= 0;
    end else begin
      if (reg_we) begin
        mem[reg_waddr] <= reg_wdata;
        n_we <= n_we + 1;
      end
      if (reg_re) n_re <= n_re + 1;
    end
  end
  assign reg_rdata = mem[reg_raddr];

  initial begin
    viol = 0;
    prev_oe = 1'b0;
    prev_scl = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe != prev_oe && scl && prev_scl) viol++;
      prev_oe = sda_oe;
      prev_scl = scl;
    end
  end

  function automatic logic [7:0] crc8_b(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda; qw(); scl = 1'b0; qw();
    end
    m_low = give_ack; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw(); m_low = 1'b0;
  endtask

  task automatic wr_txn(input logic [7:0] ra, input int n, input int bad_idx, input string tag);
    logic a;
    logic [7:0] c, p;
    p = ra;
    bus_start();
    send_byte({dev_addr, 1'b0}, a); chk(a, "R2", 32'(a), 1);
    c = crc8_b(8'h00, {dev_addr, 1'b0});
    send_byte(ra, a); chk(a, "R3", 32'(a), 1);
    c = crc8_b(c, ra);
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], a); chk(a, tag, 32'(a), 1);
      if (crc_en) begin
        c = crc8_b(c, dbuf[k]);
        if (k == bad_idx) begin
          send_byte(c ^ 8'h5A, a); chk(!a, "R8", 32'(a), 0);
          send_byte(8'h3C, a); chk(!a, "R8", 32'(a), 0);
          break;
        end
        send_byte(c, a); chk(a, "R7", 32'(a), 1);
        c = 8'h00;
      end
      exp_mem[p] = dbuf[k];
      p = p + 8'd1;
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] ra, input int n, input logic rep, input string tag);
    logic a, last;
    logic [7:0] c, d, cb, idx;
    bus_start();
    send_byte({dev_addr, 1'b0}, a); chk(a, "R2", 32'(a), 1);
    c = crc8_b(8'h00, {dev_addr, 1'b0});
    send_byte(ra, a); chk(a, "R3", 32'(a), 1);
    c = crc8_b(c, ra);
    if (!rep) begin
      bus_stop();
      c = 8'h00;
    end
    bus_start();
    send_byte({dev_addr, 1'b1}, a); chk(a, "R2", 32'(a), 1);
    c = crc8_b(c, {dev_addr, 1'b1});
    for (int k = 0; k < n; k++) begin
      last = (k == n - 1);
      idx = 8'(ra + 8'(k));
      recv_byte(d, crc_en ? 1'b1 : !last);
      chk(d == exp_mem[idx], (k > 0) ? "R4" : tag, 32'(d), 32'(exp_mem[idx]));
      if (crc_en) begin
        c = crc8_b(c, d);
        recv_byte(cb, !last);
        chk(cb == c, "R9", 32'(cb), 32'(c));
        c = 8'h00;
      end
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d, cb;
    int w0, r0;
    checks = 0;
    errors = 0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    chk(!sda_oe && !reg_we && !reg_re, "R1", {29'd0, sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    qw(2);
    chk(!sda_oe && !reg_we && !reg_re, "R1", {29'd0, sda_oe, reg_we, reg_re}, 0);

    w0 = n_we;
    bus_start();
    send_byte({7'h09, 1'b0}, a); chk(!a, "R2", 32'(a), 0);
    send_byte(8'h10, a); chk(!a, "R2", 32'(a), 0);
    bus_stop();
    chk(n_we == w0 && !sda_oe, "R2", 32'(n_we - w0), 0);

    crc_en = 1'b0;
    dbuf[0] = 8'hC3;
    wr_txn(8'h20, 1, -1, "R3");
    chk(mem[8'h20] == 8'hC3, "R3", 32'(mem[8'h20]), 32'hC3);
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    wr_txn(8'h30, 3, -1, "R4");
    rd_txn(8'h30, 3, 1'b1, "R5");
    rd_txn(8'h20, 2, 1'b0, "R6");

    crc_en = 1'b1;
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC3;
    wr_txn(8'hFE, 3, -1, "R7");
    chk(mem[8'h00] == 8'hC3, "R4", 32'(mem[8'h00]), 32'hC3);
    rd_txn(8'hFE, 3, 1'b1, "R9");
    rd_txn(8'hFF, 2, 1'b0, "R9");

    w0 = n_we;
    dbuf[0] = 8'h5E; dbuf[1] = 8'h6F;
    wr_txn(8'h50, 2, 1, "R7");
    chk(n_we - w0 == 1, "R8", 32'(n_we - w0), 1);
    chk(mem[8'h51] == init_val(8'h51), "R8", 32'(mem[8'h51]), 32'(init_val(8'h51)));

    r0 = n_re;
    bus_start();
    send_byte({dev_addr, 1'b0}, a);
    send_byte(8'h40, a);
    bus_start();
    send_byte({dev_addr, 1'b1}, a);
    recv_byte(d, 1'b1);
    chk(d == exp_mem[8'h40], "R10", 32'(d), 32'(exp_mem[8'h40]));
    recv_byte(cb, 1'b0);
    recv_byte(d, 1'b1);
    chk(d == 8'hFF, "R10", 32'(d), 32'hFF);
    bus_stop();
    chk(n_re - r0 == 1, "R10", 32'(n_re - r0), 1);

    bus_start();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    dbuf[0] = 8'h77;
    wr_txn(8'h60, 1, -1, "R11");
    chk(mem[8'h60] == 8'h77, "R11", 32'(mem[8'h60]), 32'h77);
    bus_start();
    send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    chk(!sda_oe, "R11", 32'(sda_oe), 0);
    rd_txn(8'h60, 1, 1'b1, "R11");

    dev_addr = 7'h2A;
    for (int it = 0; it < 20; it++) begin
      logic [7:0] ra;
      int n, bad;
      crc_en = 1'($urandom % 2);
      ra = 8'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
        bad = (crc_en && ($urandom % 5 == 0)) ? int'($urandom % 32'(n)) : -1;
        wr_txn(ra, n, bad, crc_en ? "R7" : "R3");
      end else begin
        logic rep;
        rep = 1'($urandom % 2);
        rd_txn(ra, n, rep, rep ? "R5" : "R6");
      end
    end
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) chk(1'b0, "R4", 32'(mem[i]), 32'(exp_mem[i]));
    checks++;
    chk(viol == 0, "R12", 32'(viol), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule